// File: doc/BRIEF.md
# Power-On Reset and Configuration Strap Sequencer

This block sits in board-control logic next to a host processor. It drives the processor's active-low power-on reset and hard reset, and the reset-configuration strap pins. Four inputs can ask for a reset: a board power-good level, a debug-port request for a full reset, a debug-port request for a soft reset, and a software request to reload the configuration. Power-on reset stays low for a programmable minimum number of reference clocks. During that time the sequencer drives a strap word that it captured when the sequence began. At the clock edge where power-on reset is released, the strap drivers let go of the pins, because the processor samples the straps only at that edge and then uses those pins for other jobs.

All request inputs pass through two-flop synchronizers. A request that stays high, or that arrives again while a sequence is running, restarts the minimum-hold count. Power-good is the one exception to synchronous timing: when it drops, power-on reset goes low at once, without waiting for a clock. The processor's own bidirectional hard-reset line is never read, so the sequencer never waits on it. A one-cycle done pulse marks the end of each sequence.

Top module: `por_strap_seq`

## Requirements
- R1: While `rst_n` is low, `por_n_o` and `hrst_n_o` are 0, `strap_oe_o` is 1, `strap_o` equals `strap_val_i` and `seq_done_o` is 0. After `rst_n` goes high, power-on reset stays low for exactly `MIN_CYC` more clock periods.
- R2: A request that is high for L consecutive rising edges holds the reset outputs low for exactly `MIN_CYC + L - 1` clock periods, never fewer than `MIN_CYC`.
- R3: A debug full-reset request drives both `por_n_o` and `hrst_n_o` low for the whole sequence.
- R4: A debug soft-reset request drives only `hrst_n_o` low. `por_n_o` stays 1, `strap_oe_o` stays 0 and `strap_o` stays 0.
- R5: A software reload request runs a full power-on sequence. It captures and drives the value that `strap_val_i` has at that moment.
- R6: The strap word is captured on the edge that enters power-on reset and stays constant while driven, even if `strap_val_i` changes. Bit layout: general word [15:0], engineering field [19:16], boot source [24:20], revision select [26:25], option A [27], option B [28].
- R7: `strap_oe_o` falls on the same edge that the sequencer releases power-on reset. It is 1 only while power-on reset is held, and `strap_o` is 0 whenever `strap_oe_o` is 0.
- R8: A request that arrives during a running sequence restarts the count. A full-reset request during a soft-reset hold turns the sequence into a power-on sequence, and `hrst_n_o` stays low throughout.
- R9: `por_n_o` goes low combinationally while `pwr_good_i` is 0. Once power-good returns, a full power-on sequence follows.
- R10: `seq_done_o` is high for exactly one cycle, in the cycle in which `hrst_n_o` has just risen at the end of a sequence.
- R11: A request first present before rising edge A shows on the reset outputs after edge A+2, which is the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer |
| pwr_good_i | input | 1 | Board power-good, high when supplies are good |
| dbg_full_req_i | input | 1 | Debug-port request for a full (power-on) reset |
| dbg_soft_req_i | input | 1 | Debug-port request for a hard reset only |
| sw_reload_req_i | input | 1 | Software request to replay the power-on sequence |
| strap_val_i | input | 29 | Strap word to present to the processor |
| por_n_o | output | 1 | Power-on reset to the processor, active low |
| hrst_n_o | output | 1 | Hard reset to the processor, active low |
| strap_o | output | 29 | Strap pin values, 0 when not driven |
| strap_oe_o | output | 1 | Strap pin driver enable |
| seq_done_o | output | 1 | One-cycle pulse when a sequence completes |

## Verification
If the hold counter is corrupted, the low time on `hrst_n_o` and `por_n_o` comes out wrong. That shows up as a wrong count of low cycles within one sequence, or the release never comes. A wrong sequencer state shows as a soft request that moves `por_n_o` or `strap_oe_o`, or as an escalation that releases the hard reset early. Both appear within the same sequence. A broken strap capture register shows as a wrong `strap_o` from the cycle after entry until release. A mis-timed driver enable shows on the release edge itself, as an enable edge that does not line up with the power-on reset edge.

// File: rtl/por_seq_pkg.sv
// Package: shared widths, strap layout and sequencer state encoding.
// Assumes: strap field widths are fixed by the processor's strap pinout.
package por_seq_pkg;
    localparam int GP_W    = 16;
    localparam int ENG_W   = 4;
    localparam int BOOT_W  = 5;
    localparam int REV_W   = 2;
    localparam int STRAP_W = GP_W + ENG_W + BOOT_W + REV_W + 2;

    // Index of each request inside the synchronizer bank
    localparam int RQ_FULL = 0;
    localparam int RQ_SOFT = 1;
    localparam int RQ_SW   = 2;
    localparam int RQ_PG   = 3;
    localparam int RQ_N    = 4;

    // Strap word, option B in the MSB down to the general word in the LSBs
    typedef struct packed {
        logic              opt_b;
        logic              opt_a;
        logic [REV_W-1:0]  rev_sel;
        logic [BOOT_W-1:0] boot_src;
        logic [ENG_W-1:0]  eng_sel;
        logic [GP_W-1:0]   gp_word;
    } strap_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_POR  = 2'd1,
        SEQ_HRST = 2'd2
    } seq_state_t;
endpackage

// File: rtl/req_sync.sv
// Module: bank of multi-stage synchronizers, one chain per request bit.
// Assumes: inputs are level signals asynchronous to clk; STAGES >= 2.
// Each bit resets to its own idle value from RST_VAL.
module req_sync #(
    parameter int             N       = 4,
    parameter int             STAGES  = 2,
    parameter logic [N-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the raw level through the synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[g]}};
            end else begin
                chain <= {chain[STAGES-2:0], d_i[g]};
            end
        end

        assign q_o[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/hold_timer.sv
// Module: minimum-hold counter for reset assertion.
// Assumes: MIN_CYC >= 2. Cleared on any request or while idle, counts while
// a sequence runs, and saturates at MIN_CYC-1, which flags expiry.
module hold_timer #(
    parameter int MIN_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(MIN_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Count hold cycles, restarting on clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt <= '0;
        end else if (run_i && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired_o = (cnt == LAST);
endmodule

// File: rtl/seq_fsm.sv
// Module: reset sequencer state machine.
// Assumes: requests are already synchronized. A full-type request wins
// over a soft one. Any request during a hold restarts the timer. Release
// and the done pulse happen on the edge after expiry with no request present.
module seq_fsm
    import por_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_full_i,
    input  logic req_soft_i,
    input  logic expired_i,
    output logic timer_clr_o,
    output logic timer_run_o,
    output logic por_start_o,
    output logic por_release_o,
    output logic por_n_o,
    output logic hrst_n_o,
    output logic done_o
);
    seq_state_t st, st_nxt;
    logic       any_req;
    logic       finish;

    // Next-state and event decode
    always_comb begin
        any_req       = req_full_i | req_soft_i;
        st_nxt        = st;
        por_start_o   = 1'b0;
        por_release_o = 1'b0;
        finish        = 1'b0;
        case (st)
            SEQ_IDLE: begin
                if (req_full_i) begin
                    st_nxt      = SEQ_POR;
                    por_start_o = 1'b1;
                end else if (req_soft_i) begin
                    st_nxt = SEQ_HRST;
                end
            end
            SEQ_POR: begin
                if (!any_req && expired_i) begin
                    st_nxt        = SEQ_IDLE;
                    por_release_o = 1'b1;
                    finish        = 1'b1;
                end
            end
            SEQ_HRST: begin
                if (req_full_i) begin
                    st_nxt      = SEQ_POR;
                    por_start_o = 1'b1;
                end else if (!req_soft_i && expired_i) begin
                    st_nxt = SEQ_IDLE;
                    finish = 1'b1;
                end
            end
            default: st_nxt = SEQ_POR;
        endcase
    end

    // State and done-pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SEQ_POR;
            done_o <= 1'b0;
        end else begin
            st     <= st_nxt;
            done_o <= finish;
        end
    end

    assign timer_clr_o = any_req | (st == SEQ_IDLE);
    assign timer_run_o = (st != SEQ_IDLE);
    assign por_n_o     = (st != SEQ_POR);
    assign hrst_n_o    = (st == SEQ_IDLE);
endmodule

// File: rtl/strap_drv.sv
// Module: strap capture register and pin driver enable.
// Assumes: start and release come from the sequencer in the cycle of the
// edge on which power-on reset enters or leaves. Outputs read 0 while floated.
module strap_drv
    import por_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               release_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [STRAP_W-1:0] strap_o,
    output logic               oe_o
);
    strap_t held;

    // Capture straps on entry, drop the driver enable on release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= strap_t'(strap_i);
            oe_o <= 1'b1;
        end else if (start_i) begin
            held <= strap_t'(strap_i);
            oe_o <= 1'b1;
        end else if (release_i) begin
            oe_o <= 1'b0;
        end
    end

    assign strap_o = oe_o ? STRAP_W'(held) : '0;
endmodule

// File: rtl/por_strap_seq.sv
// Module: top of the power-on reset and strap sequencer.
// Assumes: clk runs whenever rst_n is released. Power-good loss forces the
// power-on reset output low without a clock, and its synchronized copy also
// starts a full sequence so that release is always timed.
module por_strap_seq
    import por_seq_pkg::*;
#(
    parameter int MIN_CYC     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_good_i,
    input  logic               dbg_full_req_i,
    input  logic               dbg_soft_req_i,
    input  logic               sw_reload_req_i,
    input  logic [STRAP_W-1:0] strap_val_i,
    output logic               por_n_o,
    output logic               hrst_n_o,
    output logic [STRAP_W-1:0] strap_o,
    output logic               strap_oe_o,
    output logic               seq_done_o
);
    localparam logic [RQ_N-1:0] SYNC_IDLE = RQ_N'(1) << RQ_PG;

    logic [RQ_N-1:0] req_raw;
    logic [RQ_N-1:0] req_s;
    logic            req_full, req_soft;
    logic            timer_clr, timer_run, expired;
    logic            por_start, por_release;
    logic            seq_por_n;

    // Gather raw request levels into the synchronizer bank
    always_comb begin
        req_raw          = '0;
        req_raw[RQ_FULL] = dbg_full_req_i;
        req_raw[RQ_SOFT] = dbg_soft_req_i;
        req_raw[RQ_SW]   = sw_reload_req_i;
        req_raw[RQ_PG]   = pwr_good_i;
    end

    req_sync #(
        .N       (RQ_N),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (req_raw),
        .q_o   (req_s)
    );

    assign req_full = req_s[RQ_FULL] | req_s[RQ_SW] | ~req_s[RQ_PG];
    assign req_soft = req_s[RQ_SOFT];

    hold_timer #(
        .MIN_CYC (MIN_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (timer_clr),
        .run_i     (timer_run),
        .expired_o (expired)
    );

    seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_full_i    (req_full),
        .req_soft_i    (req_soft),
        .expired_i     (expired),
        .timer_clr_o   (timer_clr),
        .timer_run_o   (timer_run),
        .por_start_o   (por_start),
        .por_release_o (por_release),
        .por_n_o       (seq_por_n),
        .hrst_n_o      (hrst_n_o),
        .done_o        (seq_done_o)
    );

    strap_drv u_strap (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (por_start),
        .release_i (por_release),
        .strap_i   (strap_val_i),
        .strap_o   (strap_o),
        .oe_o      (strap_oe_o)
    );

    assign por_n_o = seq_por_n & pwr_good_i;
endmodule

// File: rtl/por_strap_seq_chk.sv
// Module: property checker for the sequencer, attached by bind.
// Assumes: seq_por_n is the sequencer's registered power-on reset state,
// before the power-good gate.
module por_strap_seq_chk
    import por_seq_pkg::*;
#(
    parameter int MIN_CYC = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pwr_good_i,
    input logic               hrst_n_o,
    input logic [STRAP_W-1:0] strap_o,
    input logic               strap_oe_o,
    input logic               seq_done_o,
    input logic               seq_por_n
);
    localparam int LW = $clog2(MIN_CYC) + 2;
    localparam logic [LW-1:0] LMAX = {LW{1'b1}};

    logic [LW-1:0] low_cnt;

    // Count consecutive low cycles of the hard reset output
    always_ff @(posedge clk) begin
        if (!rst_n || hrst_n_o) begin
            low_cnt <= '0;
        end else if (low_cnt != LMAX) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // R7
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_por_n) |-> $fell(strap_oe_o));

    // R7
    oe_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strap_oe_o |-> !seq_por_n);

    // R6
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_oe_o && $past(strap_oe_o)) |-> $stable(strap_o));

    // R2
    min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hrst_n_o) |-> (low_cnt >= LW'(MIN_CYC)));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_o |=> !seq_done_o);

    // R10
    done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_o |-> $rose(hrst_n_o));

    // R9
    pg_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good_i |-> ##3 !seq_por_n);
endmodule

bind por_strap_seq por_strap_seq_chk #(.MIN_CYC(MIN_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good_i (pwr_good_i),
    .hrst_n_o   (hrst_n_o),
    .strap_o    (strap_o),
    .strap_oe_o (strap_oe_o),
    .seq_done_o (seq_done_o),
    .seq_por_n  (seq_por_n)
);

// File: tb/por_strap_seq_tb.sv
`timescale 1ns/1ps
// Bench: table of request vectors with expected hold lengths, then directed
// tests for reset, latency, restart/escalation and power-good loss.
module por_strap_seq_tb;
    import por_seq_pkg::*;

    localparam int MIN = 32;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               pwr_good_i = 1'b1;
    logic               dbg_full_req_i = 1'b0;
    logic               dbg_soft_req_i = 1'b0;
    logic               sw_reload_req_i = 1'b0;
    logic [STRAP_W-1:0] strap_val_i = 29'h15A5_0F0F;
    logic               por_n_o, hrst_n_o, strap_oe_o, seq_done_o;
    logic [STRAP_W-1:0] strap_o;

    int checks = 0;
    int fails  = 0;

    // Samples gathered half a period after each rising edge
    int por_lo, hr_lo, oe_hi, done_cnt, strap_bad;
    logic [STRAP_W-1:0] strap_last;
    logic               oe_prev = 1'b0;

    por_strap_seq #(.MIN_CYC(MIN)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .pwr_good_i      (pwr_good_i),
        .dbg_full_req_i  (dbg_full_req_i),
        .dbg_soft_req_i  (dbg_soft_req_i),
        .sw_reload_req_i (sw_reload_req_i),
        .strap_val_i     (strap_val_i),
        .por_n_o         (por_n_o),
        .hrst_n_o        (hrst_n_o),
        .strap_o         (strap_o),
        .strap_oe_o      (strap_oe_o),
        .seq_done_o      (seq_done_o)
    );

    always #4 clk = ~clk;

    // Vector: kind(0 full,1 soft,2 sw) | len | strap | exp por low | exp hrst low
    localparam int VW = 2 + 4 + 29 + 8 + 8;
    localparam logic [VW-1:0] VEC [0:5] = '{
        {2'd0, 4'd1, 29'h0ABC_1234, 8'd32, 8'd32},
        {2'd1, 4'd1, 29'h1FFF_0001, 8'd0,  8'd32},
        {2'd2, 4'd1, 29'h1234_5678, 8'd32, 8'd32},
        {2'd0, 4'd5, 29'h0000_FFFF, 8'd36, 8'd36},
        {2'd1, 4'd4, 29'h1555_AAAA, 8'd0,  8'd35},
        {2'd2, 4'd3, 29'h1800_0003, 8'd34, 8'd34}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        por_lo = 0; hr_lo = 0; oe_hi = 0; done_cnt = 0; strap_bad = 0;
        strap_last = '0;
    endtask

    // Background sampler: low/high counts, done pulses, strap stability
    initial begin
        clr();
        forever begin
            @(negedge clk);
            #1;
            if (!por_n_o) por_lo++;
            if (!hrst_n_o) hr_lo++;
            if (seq_done_o) done_cnt++;
            if (strap_oe_o) begin
                oe_hi++;
                if (oe_prev && strap_o !== strap_last) strap_bad++;
                strap_last = strap_o;
            end else if (strap_o !== '0) begin
                strap_bad++;
            end
            oe_prev = strap_oe_o;
        end
    end

    task automatic set_req(input int kind, input logic v);
        case (kind)
            0: dbg_full_req_i = v;
            1: dbg_soft_req_i = v;
            default: sw_reload_req_i = v;
        endcase
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        #1;
        chk("R1 por_n in reset", por_n_o, 0);
        chk("R1 hrst_n in reset", hrst_n_o, 0);
        chk("R1 oe in reset", strap_oe_o, 1);
        chk("R1 strap in reset", strap_o, 29'h15A5_0F0F);
        chk("R1 done in reset", seq_done_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        clr();
        repeat (50) @(negedge clk);
        chk("R1 por low after reset", por_lo, MIN);
        chk("R1 hrst low after reset", hr_lo, MIN);
        chk("R10 done after reset", done_cnt, 1);

        // Table walk (R2 R3 R4 R5 R6 R7 R10)
        for (int i = 0; i < 6; i++) begin
            logic [VW-1:0] v;
            int kind, len;
            v = VEC[i];
            kind = int'(v[50:49]);
            len  = int'(v[48:45]);
            @(negedge clk);
            strap_val_i = v[44:16];
            clr();
            set_req(kind, 1'b1);
            repeat (len) @(negedge clk);
            set_req(kind, 1'b0);
            repeat (8) @(negedge clk);
            strap_val_i = ~v[44:16];
            repeat (60) @(negedge clk);
            #2;
            chk($sformatf("R2 R3 R5 vec%0d por low cycles", i), por_lo, 32'(v[15:8]));
            chk($sformatf("R2 R4 vec%0d hrst low cycles", i), hr_lo, 32'(v[7:0]));
            chk($sformatf("R7 R4 vec%0d oe cycles", i), oe_hi, 32'(v[15:8]));
            chk($sformatf("R10 vec%0d done pulses", i), done_cnt, 1);
            chk($sformatf("R6 R7 vec%0d strap glitches", i), strap_bad, 0);
            if (kind != 1)
                chk($sformatf("R6 R5 vec%0d strap value", i), strap_last, v[44:16]);
        end

        // R11: latency through synchronizers
        @(negedge clk);
        dbg_full_req_i = 1'b1;
        #1 chk("R11 por before edge A", por_n_o, 1);
        @(negedge clk); dbg_full_req_i = 1'b0;
        #1 chk("R11 por after A", por_n_o, 1);
        @(negedge clk); #1 chk("R11 por after A+1", por_n_o, 1);
        @(negedge clk); #1 chk("R11 por after A+2", por_n_o, 0);
        repeat (50) @(negedge clk);

        // R8: full request escalates a soft hold
        @(negedge clk);
        clr();
        dbg_soft_req_i = 1'b1;
        @(negedge clk); dbg_soft_req_i = 1'b0;
        repeat (9) @(negedge clk);
        dbg_full_req_i = 1'b1;
        @(negedge clk); dbg_full_req_i = 1'b0;
        repeat (60) @(negedge clk);
        #2;
        chk("R8 escalate hrst low", hr_lo, MIN + 10);
        chk("R8 escalate por low", por_lo, MIN);
        chk("R8 escalate oe", oe_hi, MIN);
        chk("R8 escalate done", done_cnt, 1);

        // R8: soft request restarts a power-on hold
        @(negedge clk);
        clr();
        dbg_full_req_i = 1'b1;
        @(negedge clk); dbg_full_req_i = 1'b0;
        repeat (9) @(negedge clk);
        dbg_soft_req_i = 1'b1;
        @(negedge clk); dbg_soft_req_i = 1'b0;
        repeat (60) @(negedge clk);
        #2;
        chk("R8 restart por low", por_lo, MIN + 10);
        chk("R8 restart hrst low", hr_lo, MIN + 10);
        chk("R8 restart done", done_cnt, 1);

        // R9: power-good loss
        @(negedge clk);
        clr();
        pwr_good_i = 1'b0;
        #1 chk("R9 por immediate", por_n_o, 0);
        repeat (3) @(negedge clk);
        pwr_good_i = 1'b1;
        repeat (60) @(negedge clk);
        #2;
        chk("R9 por low cycles", por_lo, MIN + 5);
        chk("R9 hrst low cycles", hr_lo, MIN + 2);
        chk("R9 oe cycles", oe_hi, MIN + 2);
        chk("R9 done", done_cnt, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule